// File: doc/BRIEF.md
# CABAC Binary Decode Step Unit

This block carries out a single regular-mode step of context-adaptive binary arithmetic decoding. Each request supplies two 64-bit words. The coder-state word holds the current interval range in its lower half and the code offset in its upper half. The context word holds the probability state, the value of the most probable symbol (MPS) and a normalisation bit position. The block returns a decoded bin and a packed 64-bit word. That word carries the next probability state, the next MPS value, the new range field and the new offset.

Before the interval is split, the range and the offset are left-aligned by shifting them up by the bit position. The least-probable-symbol (LPS) sub-range comes from a 64x4 ROM. The MPS sub-range is the part of the aligned range that remains. One comparison of the offset against the MPS sub-range then selects the path. The unit does not read the bitstream, does not renormalise and does not handle bypass or terminate bins. The caller provides an already normalised state and a bit position on every request.

The result is captured in a single register stage. A valid strobe on the input produces a one-cycle valid strobe on the output on the following clock.

Top module: `cabac_bin_step`

## Requirements
- R1: The probability state is taken from context bits 37:32 and the MPS value from context bit 40. The bit position is taken from context bits 4:0. No other context bit has any effect on the outputs.
- R2: The range (coder-state bits 31:0) and the offset (coder-state bits 63:32) are each shifted left by the bit position, modulo 2^32, before they are used.
- R3: The LPS range is the standard H.264 rangeTabLPS entry. Its row is the state and its column is bits 30:29 of the shifted range. It is aligned by a left shift of 23.
- R4: The MPS range is (shifted range AND 0xFF800000) minus the aligned LPS range. When the shifted offset is strictly below it, the bin equals the MPS value. In that case the result carries the MPS next state in bits 5:0, the MPS value in bit 8, MPS range bits 31:23 in bits 31:23 and the shifted offset in bits 63:32.
- R5: When the shifted offset is greater than or equal to the MPS range, the bin is the inverted MPS value. In that case the result carries the LPS next state in bits 5:0, the LPS table value in bits 31:23 and (shifted offset minus MPS range) in bits 63:32.
- R6: On the LPS path, result bit 8 is the inverted MPS value when the current state is 0. For any other state it is the unchanged MPS value.
- R7: The MPS next state is state+1 for states 0 to 61, and states 62 and 63 keep their value. The LPS next state follows the standard H.264 transIdxLPS table; for example 0→0, 5→4, 10→8 and 63→63.
- R8: Result bits 22:9 and bits 7:6 are always zero.
- R9: The result and bin appear on the clock edge that follows a cycle with valid-in high. Valid-out is high for exactly that one cycle. When valid-in is low, the result and bin keep their values.
- R10: While reset is asserted, valid-out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Request strobe |
| coder_i | input | 64 | Offset (63:32) and range (31:0) |
| ctx_i | input | 64 | MPS (40), state (37:32), bit position (4:0) |
| vld_o | output | 1 | Result strobe, one cycle |
| res_o | output | 64 | New offset (63:32), range field (31:23), MPS (8), state (5:0) |
| bin_o | output | 1 | Decoded bin |

## Verification
The vector table covers the following cases:
- Offsets on both sides of the MPS boundary, including an offset exactly equal to it, so that the strict comparison is separated from a less-or-equal one.
- All four table columns and the states 0, 5, 10, 62 and 63, which exercise both next-state rules at their saturating ends.
- State 0 with each MPS value on the LPS path, which separates the conditional MPS inversion from an unconditional one.
- A vector that sets every unused context bit and sets the low range bits below bit 23, which shows that field extraction and the 0xFF800000 mask are applied.
- A shift of 31, which confirms that bits shifted out of range and offset are lost.

After each request an idle cycle checks that the result holds. The directed tests cover reset during a pending result.

// File: rtl/cabac_pkg.sv
package cabac_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STATE_W  = 6;
  localparam int unsigned BPOS_W   = 5;
  localparam int unsigned LPS_W    = 8;
  localparam int unsigned QIDX_W   = 2;
  localparam int unsigned RFLD_LSB = 23;
  localparam int unsigned MPS_BIT  = 8;
  localparam int unsigned NSTATES  = 1 << STATE_W;
  localparam int unsigned RFLD_W   = WORD_W - RFLD_LSB;
  localparam logic [WORD_W-1:0] RANGE_MASK = {{RFLD_W{1'b1}}, {RFLD_LSB{1'b0}}};

  typedef logic [STATE_W-1:0] state_t;
endpackage

// File: rtl/cabac_rst_sync.sv
module cabac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cabac_lps_rom.sv
module cabac_lps_rom
  import cabac_pkg::*;
(
  input  state_t            state_i,
  input  logic [QIDX_W-1:0] qidx_i,
  output logic [LPS_W-1:0]  lps_o
);
  logic [4*LPS_W-1:0] row;

  // Each row lists columns 0..3 from the most significant byte down.
  always_comb begin
    unique case (state_i)
      6'd0:  row = {8'd128, 8'd176, 8'd208, 8'd240};
      6'd1:  row = {8'd128, 8'd167, 8'd197, 8'd227};
      6'd2:  row = {8'd128, 8'd158, 8'd187, 8'd216};
      6'd3:  row = {8'd123, 8'd150, 8'd178, 8'd205};
      6'd4:  row = {8'd116, 8'd142, 8'd169, 8'd195};
      6'd5:  row = {8'd111, 8'd135, 8'd160, 8'd185};
      6'd6:  row = {8'd105, 8'd128, 8'd152, 8'd175};
      6'd7:  row = {8'd100, 8'd122, 8'd144, 8'd166};
      6'd8:  row = {8'd95,  8'd116, 8'd137, 8'd158};
      6'd9:  row = {8'd90,  8'd110, 8'd130, 8'd150};
      6'd10: row = {8'd85,  8'd104, 8'd123, 8'd142};
      6'd11: row = {8'd81,  8'd99,  8'd117, 8'd135};
      6'd12: row = {8'd77,  8'd94,  8'd111, 8'd128};
      6'd13: row = {8'd73,  8'd89,  8'd105, 8'd122};
      6'd14: row = {8'd69,  8'd85,  8'd100, 8'd116};
      6'd15: row = {8'd66,  8'd80,  8'd95,  8'd110};
      6'd16: row = {8'd62,  8'd76,  8'd90,  8'd104};
      6'd17: row = {8'd59,  8'd72,  8'd86,  8'd99};
      6'd18: row = {8'd56,  8'd69,  8'd81,  8'd94};
      6'd19: row = {8'd53,  8'd65,  8'd77,  8'd89};
      6'd20: row = {8'd51,  8'd62,  8'd73,  8'd85};
      6'd21: row = {8'd48,  8'd59,  8'd69,  8'd80};
      6'd22: row = {8'd46,  8'd56,  8'd66,  8'd76};
      6'd23: row = {8'd43,  8'd53,  8'd63,  8'd72};
      6'd24: row = {8'd41,  8'd50,  8'd59,  8'd69};
      6'd25: row = {8'd39,  8'd48,  8'd56,  8'd65};
      6'd26: row = {8'd37,  8'd45,  8'd54,  8'd62};
      6'd27: row = {8'd35,  8'd43,  8'd51,  8'd59};
      6'd28: row = {8'd33,  8'd41,  8'd48,  8'd56};
      6'd29: row = {8'd32,  8'd39,  8'd46,  8'd53};
      6'd30: row = {8'd30,  8'd37,  8'd43,  8'd50};
      6'd31: row = {8'd29,  8'd35,  8'd41,  8'd48};
      6'd32: row = {8'd27,  8'd33,  8'd39,  8'd45};
      6'd33: row = {8'd26,  8'd31,  8'd37,  8'd43};
      6'd34: row = {8'd24,  8'd30,  8'd35,  8'd41};
      6'd35: row = {8'd23,  8'd28,  8'd33,  8'd39};
      6'd36: row = {8'd22,  8'd27,  8'd32,  8'd37};
      6'd37: row = {8'd21,  8'd26,  8'd30,  8'd35};
      6'd38: row = {8'd20,  8'd24,  8'd29,  8'd33};
      6'd39: row = {8'd19,  8'd23,  8'd27,  8'd31};
      6'd40: row = {8'd18,  8'd22,  8'd26,  8'd30};
      6'd41: row = {8'd17,  8'd21,  8'd25,  8'd28};
      6'd42: row = {8'd16,  8'd20,  8'd23,  8'd27};
      6'd43: row = {8'd15,  8'd19,  8'd22,  8'd25};
      6'd44: row = {8'd14,  8'd18,  8'd21,  8'd24};
      6'd45: row = {8'd14,  8'd17,  8'd20,  8'd23};
      6'd46: row = {8'd13,  8'd16,  8'd19,  8'd22};
      6'd47: row = {8'd12,  8'd15,  8'd18,  8'd21};
      6'd48: row = {8'd12,  8'd14,  8'd17,  8'd20};
      6'd49: row = {8'd11,  8'd14,  8'd16,  8'd19};
      6'd50: row = {8'd11,  8'd13,  8'd15,  8'd18};
      6'd51: row = {8'd10,  8'd12,  8'd15,  8'd17};
      6'd52: row = {8'd10,  8'd12,  8'd14,  8'd16};
      6'd53: row = {8'd9,   8'd11,  8'd13,  8'd15};
      6'd54: row = {8'd9,   8'd11,  8'd12,  8'd14};
      6'd55: row = {8'd8,   8'd10,  8'd12,  8'd14};
      6'd56: row = {8'd8,   8'd9,   8'd11,  8'd13};
      6'd57: row = {8'd7,   8'd9,   8'd11,  8'd12};
      6'd58: row = {8'd7,   8'd9,   8'd10,  8'd12};
      6'd59: row = {8'd7,   8'd8,   8'd10,  8'd11};
      6'd60: row = {8'd6,   8'd8,   8'd9,   8'd11};
      6'd61: row = {8'd6,   8'd7,   8'd9,   8'd10};
      6'd62: row = {8'd6,   8'd7,   8'd8,   8'd9};
      default: row = {8'd2, 8'd2,   8'd2,   8'd2};
    endcase
  end

  assign lps_o = row[LPS_W*(3 - int'(qidx_i)) +: LPS_W];
endmodule

// File: rtl/cabac_state_xlat.sv
module cabac_state_xlat
  import cabac_pkg::*;
(
  input  state_t state_i,
  output state_t nxt_mps_o,
  output state_t nxt_lps_o
);
  localparam state_t TOP_STATE  = state_t'(NSTATES - 1);
  localparam state_t SAT_STATE  = state_t'(NSTATES - 2);

  // MPS transition is a saturating increment; the two top states hold.
  always_comb begin
    if (state_i >= SAT_STATE) nxt_mps_o = state_i;
    else                      nxt_mps_o = state_i + state_t'(1);
  end

  always_comb begin
    unique case (state_i)
      6'd0,  6'd1:                      nxt_lps_o = 6'd0;
      6'd2:                             nxt_lps_o = 6'd1;
      6'd3,  6'd4:                      nxt_lps_o = 6'd2;
      6'd5,  6'd6:                      nxt_lps_o = 6'd4;
      6'd7:                             nxt_lps_o = 6'd5;
      6'd8:                             nxt_lps_o = 6'd6;
      6'd9:                             nxt_lps_o = 6'd7;
      6'd10:                            nxt_lps_o = 6'd8;
      6'd11, 6'd12:                     nxt_lps_o = 6'd9;
      6'd13, 6'd14:                     nxt_lps_o = 6'd11;
      6'd15:                            nxt_lps_o = 6'd12;
      6'd16, 6'd17:                     nxt_lps_o = 6'd13;
      6'd18, 6'd19:                     nxt_lps_o = 6'd15;
      6'd20, 6'd21:                     nxt_lps_o = 6'd16;
      6'd22, 6'd23:                     nxt_lps_o = 6'd18;
      6'd24, 6'd25:                     nxt_lps_o = 6'd19;
      6'd26, 6'd27:                     nxt_lps_o = 6'd21;
      6'd28, 6'd29:                     nxt_lps_o = 6'd22;
      6'd30:                            nxt_lps_o = 6'd23;
      6'd31, 6'd32:                     nxt_lps_o = 6'd24;
      6'd33:                            nxt_lps_o = 6'd25;
      6'd34, 6'd35:                     nxt_lps_o = 6'd26;
      6'd36, 6'd37:                     nxt_lps_o = 6'd27;
      6'd38:                            nxt_lps_o = 6'd28;
      6'd39, 6'd40:                     nxt_lps_o = 6'd29;
      6'd41, 6'd42, 6'd43:              nxt_lps_o = 6'd30;
      6'd44:                            nxt_lps_o = 6'd31;
      6'd45, 6'd46:                     nxt_lps_o = 6'd32;
      6'd47, 6'd48, 6'd49:              nxt_lps_o = 6'd33;
      6'd50, 6'd51:                     nxt_lps_o = 6'd34;
      6'd52, 6'd53, 6'd54:              nxt_lps_o = 6'd35;
      6'd55, 6'd56, 6'd57:              nxt_lps_o = 6'd36;
      6'd58, 6'd59, 6'd60:              nxt_lps_o = 6'd37;
      6'd61, 6'd62:                     nxt_lps_o = 6'd38;
      default:                          nxt_lps_o = TOP_STATE;
    endcase
  end
endmodule

// File: rtl/cabac_bin_core.sv
module cabac_bin_core
  import cabac_pkg::*;
(
  input  logic [2*WORD_W-1:0] coder_i,
  input  logic [2*WORD_W-1:0] ctx_i,
  output logic [2*WORD_W-1:0] res_o,
  output logic                bin_o
);
  state_t              state;
  logic                mps;
  logic [BPOS_W-1:0]   bpos;
  logic [WORD_W-1:0]   range_sh, off_sh;
  logic [LPS_W-1:0]    lps_val;
  logic [WORD_W-1:0]   lps_al, mps_rng;
  logic                take_mps;
  state_t              nxt_mps, nxt_lps;
  logic [WORD_W-1:0]   lo_word, hi_word;
  logic                unused_ctx_bits;

  assign state    = ctx_i[WORD_W +: STATE_W];
  assign mps      = ctx_i[WORD_W + MPS_BIT];
  assign bpos     = ctx_i[BPOS_W-1:0];
  assign unused_ctx_bits = ^{ctx_i[2*WORD_W-1:WORD_W+MPS_BIT+1],
                             ctx_i[WORD_W+MPS_BIT-1:WORD_W+STATE_W],
                             ctx_i[WORD_W-1:BPOS_W]};

  assign range_sh = coder_i[WORD_W-1:0] << bpos;
  assign off_sh   = coder_i[2*WORD_W-1:WORD_W] << bpos;

  cabac_lps_rom u_rom (
    .state_i (state),
    .qidx_i  (range_sh[WORD_W-2 -: QIDX_W]),
    .lps_o   (lps_val)
  );

  cabac_state_xlat u_xlat (
    .state_i   (state),
    .nxt_mps_o (nxt_mps),
    .nxt_lps_o (nxt_lps)
  );

  assign lps_al   = WORD_W'(lps_val) << RFLD_LSB;
  assign mps_rng  = (range_sh & RANGE_MASK) - lps_al;
  assign take_mps = off_sh < mps_rng;

  always_comb begin
    lo_word = '0;
    if (take_mps) begin
      lo_word[STATE_W-1:0]        = nxt_mps;
      lo_word[MPS_BIT]            = mps;
      lo_word[WORD_W-1:RFLD_LSB]  = mps_rng[WORD_W-1:RFLD_LSB];
      hi_word                     = off_sh;
      bin_o                       = mps;
    end else begin
      lo_word[STATE_W-1:0]        = nxt_lps;
      lo_word[MPS_BIT]            = (state == '0) ? ~mps : mps;
      lo_word[WORD_W-1:RFLD_LSB]  = lps_al[WORD_W-1:RFLD_LSB];
      hi_word                     = off_sh - mps_rng;
      bin_o                       = ~mps;
    end
  end

  assign res_o = {hi_word, lo_word};
endmodule

// File: rtl/cabac_bin_step.sv
module cabac_bin_step
  import cabac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic [2*WORD_W-1:0] coder_i,
  input  logic [2*WORD_W-1:0] ctx_i,
  output logic                vld_o,
  output logic [2*WORD_W-1:0] res_o,
  output logic                bin_o
);
  logic                rst_q_n;
  logic [2*WORD_W-1:0] res_c, res_d, res_q;
  logic                bin_c, bin_d, bin_q;
  logic                vld_d, vld_q;

  cabac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  cabac_bin_core u_core (
    .coder_i (coder_i),
    .ctx_i   (ctx_i),
    .res_o   (res_c),
    .bin_o   (bin_c)
  );

  // Next-state: load on a request, hold otherwise.
  always_comb begin
    vld_d = vld_i;
    res_d = res_q;
    bin_d = bin_q;
    if (vld_i) begin
      res_d = res_c;
      bin_d = bin_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= 1'b0;
    else          vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    res_q <= res_d;
    bin_q <= bin_d;
  end

  assign vld_o = vld_q;
  assign res_o = res_q;
  assign bin_o = bin_q;
endmodule

// File: rtl/cabac_bin_step_chk.sv
module cabac_bin_step_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_q_n,
  input logic        vld_i,
  input logic [63:0] ctx_i,
  input logic        vld_o,
  input logic [63:0] res_o,
  input logic        bin_o
);
  logic       mps_q;
  logic [5:0] st_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mps_q <= 1'b0;
      st_q  <= 6'd0;
    end else if (vld_i) begin
      mps_q <= ctx_i[40];
      st_q  <= ctx_i[37:32];
    end
  end

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_i |=> vld_o);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !vld_i |=> (!vld_o && $stable(res_o) && $stable(bin_o)));
  assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_o |-> (res_o[22:9] == 14'd0 && res_o[7:6] == 2'd0));
  assert_mps_path_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && bin_o == mps_q) |-> (res_o[8] == mps_q &&
      res_o[63:32] < {res_o[31:23], 23'd0}));
  assert_mps_next_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && bin_o == mps_q) |->
      (res_o[5:0] == ((st_q >= 6'd62) ? st_q : st_q + 6'd1)));
  assert_lps_flip_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && bin_o != mps_q) |->
      (res_o[8] == ((st_q == 6'd0) ? ~mps_q : mps_q)));
  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |-> !vld_o);
endmodule

bind cabac_bin_step cabac_bin_step_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_q_n (rst_q_n),
  .vld_i   (vld_i),
  .ctx_i   (ctx_i),
  .vld_o   (vld_o),
  .res_o   (res_o),
  .bin_o   (bin_o)
);

// File: tb/tb_cabac_bin_step.sv
module tb_cabac_bin_step;
  logic        clk;
  logic        rst_n;
  logic        vld_i;
  logic [63:0] coder_i;
  logic [63:0] ctx_i;
  logic        vld_o;
  logic [63:0] res_o;
  logic        bin_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam int NV = 8;
  // v0 R4 R7 MPS path; v1 R3 R5 R6 state0 LPS; v2 R1 R2 MPS shift 1;
  // v3 R5 R6 LPS keep MPS; v4 R5 R7 offset equal to boundary, state 63;
  // v5 R1 R2 R8 junk context bits and low range bits; v6 R2 shift 31;
  // v7 R6 state0 LPS with MPS 1
  localparam logic [63:0] V_CODER [NV] = '{
    64'h10000000_FF000000, 64'h90000000_FF000000,
    64'h20000000_7F800000, 64'h90000000_C0000000,
    64'h7F000000_80000000, 64'h01000000_0A123456,
    64'h00000001_00000001, 64'hFF000000_FF000000};
  localparam logic [63:0] V_CTX [NV] = '{
    64'h00000000_00000000, 64'h00000000_00000000,
    64'h0000010A_00000001, 64'h0000010A_00000000,
    64'h0000003F_00000000, 64'hFFFFFF3E_FFFFFFE4,
    64'h00000005_0000001F, 64'h00000100_00000000};
  localparam logic [63:0] V_RES [NV] = '{
    64'h10000000_87000001, 64'h09000000_78000100,
    64'h40000000_B800010B, 64'h0D800000_3D800108,
    64'h00000000_0100003F, 64'h10000000_9D80013E,
    64'h37800000_37800004, 64'h78000000_78000000};
  localparam logic V_BIN [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  cabac_bin_step dut (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .coder_i(coder_i),
    .ctx_i(ctx_i), .vld_o(vld_o), .res_o(res_o), .bin_o(bin_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; vld_i = 1'b0; coder_i = '0; ctx_i = '0;
    repeat (3) @(negedge clk);
    check1("R10 reset state vld_o", vld_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table walk: R1..R9 (tags per vector above)
    for (int i = 0; i < NV; i++) begin
      vld_i = 1'b1; coder_i = V_CODER[i]; ctx_i = V_CTX[i];
      @(negedge clk);
      vld_i = 1'b0; coder_i = '1; ctx_i = '1;
      check1($sformatf("R9 vector %0d vld_o", i), vld_o, 1'b1);
      check64($sformatf("R4 R5 vector %0d result", i), res_o, V_RES[i]);
      check1($sformatf("R4 R5 vector %0d bin", i), bin_o, V_BIN[i]);
      @(negedge clk);
      check1($sformatf("R9 vector %0d pulse ends", i), vld_o, 1'b0);
      check64($sformatf("R9 vector %0d result held", i), res_o, V_RES[i]);
    end

    // Back-to-back requests: R9 each result lands one cycle after its strobe
    vld_i = 1'b1; coder_i = V_CODER[0]; ctx_i = V_CTX[0];
    @(negedge clk);
    coder_i = V_CODER[1]; ctx_i = V_CTX[1];
    check64("R9 back-to-back first", res_o, V_RES[0]);
    @(negedge clk);
    vld_i = 1'b0;
    check1("R9 back-to-back second vld_o", vld_o, 1'b1);
    check64("R9 back-to-back second", res_o, V_RES[1]);
    held = res_o;
    @(negedge clk);

    // R10: reset during a pending strobe clears vld_o at once
    vld_i = 1'b1; coder_i = V_CODER[2]; ctx_i = V_CTX[2];
    @(posedge clk);
    #3;
    vld_i = 1'b0;
    rst_n = 1'b0;
    #2;
    check1("R10 async clear of vld_o", vld_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check1("R10 vld_o low after release", vld_o, 1'b0);
    check1("R9 idle keeps bin", bin_o, V_BIN[2]);
    if (held == 64'h0) check1("R9 held sanity", 1'b0, 1'b1);

    done = 1;
    finish_run();
  end
endmodule